// File: doc/BRIEF.md
# Golden Vector Workload Checker

This block runs one functional test pass on a device under test. Software or a sequencer first loads the expected output for every stimulus index into an internal golden memory through a write port. A start pulse then launches a run. The block drives a counting stimulus on the device inputs, beginning at zero and advancing by one each clock. It compares every returned output word against the golden word for the same index, in step with the device's fixed pipeline latency.

Each disagreement increments a saturating error counter and sets a sticky fail flag. The disagreement is also pushed into a small log queue together with its vector index and the bitwise difference. A one-cycle done pulse closes the run. An injection sequencer typically alternates "corrupt one location, run, read fail and log, restore" without ever stopping the device clock.

Top module: `golden_run_checker`

## Requirements
- R1: After reset, busy, done, fail, log_valid and log_overflow are 0, err_count is 0 and dut_in is 0.
- R2: A start accepted while idle with run_len = N (1 to DEPTH) drives dut_in = 0, 1, 2, ..., N-1 on consecutive cycles starting in the cycle after the start edge, then returns dut_in to 0.
- R3: The dut_out word sampled LAT cycles after dut_in held value k is compared with golden entry k. Words outside that alignment, or beyond index N-1, are never compared.
- R4: done is a single-cycle pulse that appears N+LAT clock edges after the edge that accepted start. busy is 1 from the accepting edge until done rises, and 0 in the done cycle.
- R5: fail is 1 exactly when at least one compare of the run disagreed. It is valid in the done cycle, holds afterwards, and is cleared by the next accepted start.
- R6: err_count counts disagreeing compares of the current run and stops at 2^ERR_W-1 instead of wrapping. An accepted start clears it.
- R7: Each disagreement enqueues one log entry of {vector index, golden XOR dut_out}, oldest first. log_valid flags a present head entry, and a high log_pop removes it at the clock edge.
- R8: A disagreement that arrives while the log holds LOG_DEPTH entries is dropped and sets log_overflow. An accepted start empties the log and clears log_overflow.
- R9: A start pulse while busy is ignored: the stimulus sequence, the run length and the done timing of the running pass are unchanged.
- R10: A start with run_len = 0 is ignored and leaves the block idle.
- R11: gold_we writes gold_wdata into golden entry gold_waddr, and the next run compares against the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run launch pulse |
| run_len | input | CNT_W | Number of vectors in the run, sampled at an accepted start |
| gold_we | input | 1 | Golden memory write enable |
| gold_waddr | input | ADDR_W | Golden memory write index |
| gold_wdata | input | OUT_W | Golden memory write data |
| dut_in | output | ADDR_W | Counting stimulus to the device |
| dut_out | input | OUT_W | Device response |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag of the last run |
| err_count | output | ERR_W | Saturating mismatch count |
| log_valid | output | 1 | Log head entry present |
| log_pop | input | 1 | Remove log head entry |
| log_cycle | output | ADDR_W | Vector index of log head |
| log_diff | output | OUT_W | Golden XOR response of log head |
| log_overflow | output | 1 | A mismatch was dropped because the log was full |

## Verification
A slip in the address delay chain shows as a mismatch at every index of an otherwise clean run. It is flagged at the first compared vector, LAT+1 cycles after start. A wrong stimulus counter shows on dut_in at once, and it also moves the done pulse away from its exact N+LAT edge position. Faults in the error counter, the fail flag or the log pointers stay hidden until done. At that point they show as a count, flag or entry sequence that does not match the mismatches the bench planted.

// File: rtl/gvc_pkg.sv
package gvc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_DRAIN = 2'd2
  } run_phase_e;
endpackage

// File: rtl/gvc_stim.sv
module gvc_stim #(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [CNT_W-1:0]  len,
  output logic              issue_vld,
  output logic [ADDR_W-1:0] issue_idx,
  output logic              issue_last
);
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0]  len_q, len_d;

  assign issue_last = vld_q && (CNT_W'(idx_q) == len_q - CNT_W'(1));
  assign issue_vld  = vld_q;
  assign issue_idx  = idx_q;

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    len_d = len_q;
    if (launch) begin
      vld_d = 1'b1;
      idx_d = '0;
      len_d = len;
    end else if (vld_q) begin
      if (issue_last) begin
        vld_d = 1'b0;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      len_q <= '0;
    end else begin
      vld_q <= vld_d;
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end

  // R9: a launch never lands on an active issue phase
  assert_launch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !vld_q);
  // R2: consecutive issued indices step by one
  assert_issue_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !issue_last) |=> (vld_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/gvc_align.sv
module gvc_align #(
  parameter int ADDR_W = 5,
  parameter int OUT_W  = 8,
  parameter int DEPTH  = 32,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [OUT_W-1:0]  wr_data,
  input  logic              rq_vld,
  input  logic              rq_last,
  input  logic [ADDR_W-1:0] rq_idx,
  output logic              cmp_vld,
  output logic              cmp_last,
  output logic [ADDR_W-1:0] cmp_idx,
  output logic [OUT_W-1:0]  cmp_exp
);
  localparam int CH_W = ADDR_W + 2;

  logic [OUT_W-1:0]  gmem [DEPTH];
  logic [CH_W-1:0]   tap;
  logic              tap_v, tap_l;
  logic [ADDR_W-1:0] tap_i;

  // delay the read request so the registered read lands with the response
  if (LAT > 1) begin : g_dly
    logic [CH_W-1:0] sr [LAT-1];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < LAT-1; s++) sr[s] <= '0;
      end else begin
        sr[0] <= {rq_vld, rq_last, rq_idx};
        for (int s = 1; s < LAT-1; s++) sr[s] <= sr[s-1];
      end
    end
    assign tap = sr[LAT-2];
  end else begin : g_nodly
    assign tap = {rq_vld, rq_last, rq_idx};
  end

  assign tap_v = tap[CH_W-1];
  assign tap_l = tap[CH_W-2];
  assign tap_i = tap[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) gmem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (tap_v) cmp_exp <= gmem[tap_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld  <= 1'b0;
      cmp_last <= 1'b0;
      cmp_idx  <= '0;
    end else begin
      cmp_vld  <= tap_v;
      cmp_last <= tap_v & tap_l;
      if (tap_v) cmp_idx <= tap_i;
    end
  end

  // R3: compared indices follow the issue order without gaps
  assert_cmp_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && !cmp_last) |=> (cmp_vld && cmp_idx == $past(cmp_idx) + 1'b1));
endmodule

// File: rtl/gvc_logfifo.sv
module gvc_logfifo #(
  parameter int IW    = 5,
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic [DW-1:0] push_diff,
  input  logic          pop,
  output logic          valid,
  output logic [IW-1:0] head_idx,
  output logic [DW-1:0] head_diff,
  output logic          overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = IW + DW;

  logic [EW-1:0] store [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && valid && !flush;
  assign {head_idx, head_diff} = store[rp_q];
  assign overflow = ovf_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = push_ok ? bump(wp_q) : wp_q;
    rp_d  = pop_ok  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
    ovf_d = ovf_q | (push && full);
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wp_q] <= {push_idx, push_diff};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R8: a push into a full log is flagged
  assert_no_silent_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !flush) |=> overflow);
  // R7: occupancy stays within the storage
  assert_log_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/golden_run_checker.sv
module golden_run_checker
  import gvc_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int OUT_W     = 8,
  parameter int LAT       = 2,
  parameter int LOG_DEPTH = 4,
  parameter int ERR_W     = 4,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  run_len,
  input  logic              gold_we,
  input  logic [ADDR_W-1:0] gold_waddr,
  input  logic [OUT_W-1:0]  gold_wdata,
  output logic [ADDR_W-1:0] dut_in,
  input  logic [OUT_W-1:0]  dut_out,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ERR_W-1:0]  err_count,
  output logic              log_valid,
  input  logic              log_pop,
  output logic [ADDR_W-1:0] log_cycle,
  output logic [OUT_W-1:0]  log_diff,
  output logic              log_overflow
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  run_phase_e        ph_q, ph_d;
  logic              accept;
  logic              iss_vld, iss_last;
  logic [ADDR_W-1:0] iss_idx;
  logic              cmp_vld, cmp_last;
  logic [ADDR_W-1:0] cmp_idx;
  logic [OUT_W-1:0]  cmp_exp;
  logic              miss;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              fail_q, fail_d, done_q;

  assign accept = start && (ph_q == PH_IDLE) && (run_len != '0);
  assign miss   = cmp_vld && (cmp_exp != dut_out);

  gvc_stim #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stim (
    .clk(clk), .rst_n(rst_n), .launch(accept), .len(run_len),
    .issue_vld(iss_vld), .issue_idx(iss_idx), .issue_last(iss_last)
  );

  gvc_align #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .LAT(LAT)) u_align (
    .clk(clk), .rst_n(rst_n),
    .wr_en(gold_we), .wr_addr(gold_waddr), .wr_data(gold_wdata),
    .rq_vld(iss_vld), .rq_last(iss_last), .rq_idx(iss_idx),
    .cmp_vld(cmp_vld), .cmp_last(cmp_last), .cmp_idx(cmp_idx), .cmp_exp(cmp_exp)
  );

  gvc_logfifo #(.IW(ADDR_W), .DW(OUT_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk(clk), .rst_n(rst_n), .flush(accept),
    .push(miss), .push_idx(cmp_idx), .push_diff(cmp_exp ^ dut_out),
    .pop(log_pop), .valid(log_valid), .head_idx(log_cycle),
    .head_diff(log_diff), .overflow(log_overflow)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept)   ph_d = PH_ISSUE;
      PH_ISSUE: if (iss_last) ph_d = PH_DRAIN;
      PH_DRAIN: if (cmp_last) ph_d = PH_IDLE;
      default:                ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    err_d  = err_q;
    fail_d = fail_q;
    if (accept) begin
      err_d  = '0;
      fail_d = 1'b0;
    end else if (miss) begin
      fail_d = 1'b1;
      if (err_q != ERR_MAX) err_d = err_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      err_q  <= '0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      err_q  <= err_d;
      fail_q <= fail_d;
      done_q <= cmp_last;
    end
  end

  assign dut_in    = iss_idx;
  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign err_count = err_q;

  // R4: done lasts one cycle
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4: the block is idle when done is shown
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5: the fail flag agrees with the error count at the end of a run
  assert_fail_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (err_count != '0)));
  // R6: a full count never wraps within a run
  assert_err_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == ERR_MAX && !accept) |=> (err_count == ERR_MAX));
  // R10: an empty run request leaves the block idle
  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_len == '0 && !busy) |=> !busy);
endmodule

// File: tb/golden_run_checker_bench.sv
`timescale 1ns/1ps
module golden_run_checker_bench;
  localparam int DEPTH = 32, OUT_W = 8, LAT = 2, LOG_DEPTH = 4, ERR_W = 4;
  localparam int ADDR_W = 5, CNT_W = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [CNT_W-1:0]  run_len;
  logic              gold_we;
  logic [ADDR_W-1:0] gold_waddr;
  logic [OUT_W-1:0]  gold_wdata;
  logic [ADDR_W-1:0] dut_in;
  logic [OUT_W-1:0]  dut_out;
  logic              busy, done, fail, log_valid, log_pop, log_overflow;
  logic [ERR_W-1:0]  err_count;
  logic [ADDR_W-1:0] log_cycle;
  logic [OUT_W-1:0]  log_diff;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  golden_run_checker #(.DEPTH(DEPTH), .OUT_W(OUT_W), .LAT(LAT),
                       .LOG_DEPTH(LOG_DEPTH), .ERR_W(ERR_W)) u_golden_run_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .gold_we(gold_we), .gold_waddr(gold_waddr), .gold_wdata(gold_wdata),
    .dut_in(dut_in), .dut_out(dut_out), .busy(busy), .done(done), .fail(fail),
    .err_count(err_count), .log_valid(log_valid), .log_pop(log_pop),
    .log_cycle(log_cycle), .log_diff(log_diff), .log_overflow(log_overflow)
  );

  // device model: LAT-stage pipeline of a fixed function, with plantable corruption
  logic [OUT_W-1:0]  corrupt [DEPTH];
  logic [ADDR_W-1:0] pipe [LAT];
  always_ff @(posedge clk) begin
    pipe[0] <= dut_in;
    for (int s = 1; s < LAT; s++) pipe[s] <= pipe[s-1];
  end
  function automatic logic [OUT_W-1:0] golden_of(input int k);
    return OUT_W'(k * 3 + 5);
  endfunction
  assign dut_out = golden_of(int'(pipe[LAT-1])) ^ corrupt[pipe[LAT-1]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_corrupt();
    for (int k = 0; k < DEPTH; k++) corrupt[k] = '0;
  endtask

  task automatic write_gold(input int k, input logic [OUT_W-1:0] v);
    @(negedge clk);
    gold_we = 1'b1; gold_waddr = ADDR_W'(k); gold_wdata = v;
    @(negedge clk);
    gold_we = 1'b0;
  endtask

  // launch a run, check stimulus (R2) and done timing (R4); optional start poke while busy (R9)
  task automatic run_case(input string tag, input int len, input int poke_at);
    int n;
    @(negedge clk);
    run_len = CNT_W'(len); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    chk(busy == 1'b1, "R4", {tag, " busy after start"}, busy, 1);
    while (!done && n < 1000) begin
      chk(dut_in == ADDR_W'((n < len) ? n : 0), "R2", {tag, " stimulus"}, dut_in,
          (n < len) ? n : 0);
      start = (n == poke_at);
      if (n == poke_at) run_len = CNT_W'(3);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(n == len + LAT, "R4", {tag, " done edge"}, n, len + LAT);
    chk(busy == 1'b0, "R4", {tag, " idle at done"}, busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R4", {tag, " done single pulse"}, done, 0);
  endtask

  task automatic expect_log(input string req, input int idx, input int diff);
    chk(log_valid == 1'b1, req, "log entry present", log_valid, 1);
    chk(log_cycle == ADDR_W'(idx), req, "log index", log_cycle, idx);
    chk(log_diff == OUT_W'(diff), req, "log diff", log_diff, diff);
    log_pop = 1'b1;
    @(negedge clk);
    log_pop = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !fail, "R1", "flags after reset", {busy, done, fail}, 0);
    chk(err_count == 0, "R1", "err_count after reset", err_count, 0);
    chk(!log_valid && !log_overflow, "R1", "log after reset", {log_valid, log_overflow}, 0);
    chk(dut_in == 0, "R1", "dut_in after reset", dut_in, 0);
  endtask

  task automatic t_clean();
    clear_corrupt();
    run_case("clean", 10, -1);
    chk(fail == 1'b0, "R5", "clean fail", fail, 0);
    chk(err_count == 0, "R3", "clean count", err_count, 0);
    chk(log_valid == 1'b0, "R7", "clean log empty", log_valid, 0);
  endtask

  task automatic t_two_misses();
    clear_corrupt();
    corrupt[3] = 8'h01; corrupt[7] = 8'h80; corrupt[15] = 8'h55;
    run_case("two", 12, -1);
    chk(fail == 1'b1, "R5", "two fail", fail, 1);
    chk(err_count == 2, "R3", "two count, index 15 outside run", err_count, 2);
    expect_log("R7", 3, 8'h01);
    expect_log("R7", 7, 8'h80);
    chk(log_valid == 1'b0, "R7", "log drained", log_valid, 0);
    chk(fail == 1'b1, "R5", "fail holds after done", fail, 1);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < DEPTH; k++) corrupt[k] = 8'hFF;
    run_case("all", DEPTH, -1);
    chk(err_count == 4'hF, "R6", "saturated count", err_count, 15);
    chk(log_overflow == 1'b1, "R8", "overflow set", log_overflow, 1);
    for (int k = 0; k < LOG_DEPTH; k++) expect_log("R8", k, 8'hFF);
    chk(log_valid == 1'b0, "R8", "only LOG_DEPTH kept", log_valid, 0);
  endtask

  task automatic t_restart_clears();
    clear_corrupt();
    run_case("restart", 5, -1);
    chk(fail == 1'b0, "R5", "fail cleared by start", fail, 0);
    chk(err_count == 0, "R6", "count cleared by start", err_count, 0);
    chk(log_overflow == 1'b0, "R8", "overflow cleared by start", log_overflow, 0);
  endtask

  task automatic t_busy_start();
    clear_corrupt();
    run_case("poke", 10, 3);
    chk(err_count == 0, "R9", "poke run clean", err_count, 0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    run_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || done || dut_in != 0) begin
        chk(1'b0, "R10", "zero length started", {busy, done}, 0);
        break;
      end
    end
    chk(busy == 1'b0, "R10", "zero length idle", busy, 0);
  endtask

  task automatic t_rewrite();
    clear_corrupt();
    write_gold(5, golden_of(5) ^ 8'h3C);
    run_case("rewrite", 8, -1);
    chk(err_count == 1, "R11", "rewritten entry count", err_count, 1);
    expect_log("R11", 5, 8'h3C);
    write_gold(5, golden_of(5));
    run_case("restored", 8, -1);
    chk(err_count == 0, "R11", "restored entry count", err_count, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; run_len = '0; gold_we = 1'b0;
    gold_waddr = '0; gold_wdata = '0; log_pop = 1'b0;
    clear_corrupt();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int k = 0; k < DEPTH; k++) write_gold(k, golden_of(k));
    t_clean();
    t_two_misses();
    t_saturate();
    t_restart_clears();
    t_busy_start();
    t_zero_len();
    t_rewrite();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule